// File: doc/BRIEF.md
# Serial EEPROM Pin Controller with Software Bit-Bang Override

This block sits between a chip and a three-wire serial EEPROM that uses a chip-select/clock/data-in/data-out protocol. It owns the chip-select and data-in pins outright. It shares the serial clock pin with one indicator LED function and the data-out pin with another. A mode input picks who drives the serial pins. In automatic mode an internal sequencer issues one read command from address zero and then clocks through the whole device. In software mode a small control/status register lets firmware set chip select, clock and data-in one bit at a time and read back the data returned by the EEPROM.

When reset is released, the block samples the level on the shared clock/LED pad, which is left undriven during reset. A high level means an EEPROM is attached. That flag sits read-only in the status register. When no device was found, automatic mode reports that fact and never starts a read. A mode change always holds chip select low for one cycle first, so the EEPROM never sees half a command from either owner.

Top module: `mw_eeprom_port`

## Requirements
- R1: While reset is asserted, chip select is low and both shared pads (clock pad and data-out pad) are undriven (`sk_pin_oe` = 0, `do_pin_oe` = 0).
- R2: On the first clock edge after reset is released, the clock pad level is captured into `reg_rdata[3]` (1 = EEPROM present, 0 = absent). That bit cannot be written and stays constant until the next reset, whatever the pad does later.
- R3: In software mode (`auto_mode` = 0), a register write of `reg_wdata` drives chip select from bit 2, the serial clock from bit 1 and data-in from bit 0. The pins follow from the cycle after the write edge. Bits 2 and 1 read back on `reg_rdata[2]` and `reg_rdata[1]`.
- R4: `reg_rdata[0]` returns the data-out line as captured on the clock edge after each rising edge of the serial clock. A change on data-out while the serial clock stays high does not alter it.
- R5: In automatic mode the pins come only from the sequencer. Register bits set in software mode have no effect on chip select.
- R6: After a start pulse in automatic mode with an EEPROM present, chip select stays high for 2*(3+ADDR_W+DATA_W*WORDS) cycles. The serial clock rises 3+ADDR_W+DATA_W*WORDS times. At the first three rises data-in carries 1,1,0 (read command), followed by ADDR_W zero address bits and then zeros.
- R7: With no EEPROM detected and automatic mode selected, `auto_absent` is 1 and a start pulse never raises chip select. In software mode `auto_absent` is 0.
- R8: After any change of `auto_mode`, chip select is low for the next cycle. From the cycle after that, the new owner drives it.
- R9: While chip select is high, the clock pad carries the serial clock and the data-out pad is released (`do_pin_oe` = 0). While chip select is low (after detection), the clock pad carries `led_sk_fn` and the data-out pad drives `led_do_fn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_mode | input | 1 | 1 = sequencer owns the pins, 0 = software register owns them |
| auto_start | input | 1 | One-cycle pulse that starts a full read in automatic mode |
| reg_wr | input | 1 | Write strobe for the control register |
| reg_wdata | input | 3 | Bit 2 chip select, bit 1 serial clock, bit 0 data-in |
| reg_rdata | output | 4 | Bit 3 presence, bits 2..1 written values, bit 0 captured data-out |
| auto_absent | output | 1 | Automatic mode selected but no EEPROM detected |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_di | output | 1 | EEPROM data-in |
| ee_do_i | input | 1 | EEPROM data-out |
| sk_pin_i | input | 1 | Level seen on the shared clock/LED pad |
| sk_pin_o | output | 1 | Value driven onto the shared clock/LED pad |
| sk_pin_oe | output | 1 | Drive enable of the shared clock/LED pad |
| led_sk_fn | input | 1 | LED function routed to the clock pad when idle |
| led_do_fn | input | 1 | LED function routed to the data-out pad when idle |
| do_pin_o | output | 1 | Value driven onto the shared data-out/LED pad |
| do_pin_oe | output | 1 | Drive enable of the shared data-out/LED pad |

## Verification
The bench sweeps all eight register values in software mode and checks each pin and each pad routing. A swapped bit or an LED that stayed on the pad during an access would show up there. It raises the clock while data-out changes at different times. A design that passed data-out straight through, or captured on every cycle, returns the wrong bit. It switches modes with software chip select held high. Without the one-cycle low gap, chip select would stay high across the handover. It replays a full automatic read bit by bit and reruns reset with the pad pulled low. That second run catches a design that starts a read with no EEPROM attached or lets the presence flag follow the pad later.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_CMD  = 2'd1,
        SQ_DATA = 2'd2
    } sq_state_e;

endpackage

// File: rtl/mw_presence.sv
// Samples the shared pad once, on the first edge after reset release.
module mw_presence (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic present,
    output logic done
);

    typedef struct packed {
        logic done;
        logic present;
    } det_t;

    det_t d, q;

    always_comb begin
        d = q;
        if (!q.done) begin
            d.done    = 1'b1;
            d.present = pin_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign present = q.present;
    assign done    = q.done;

endmodule

// File: rtl/mw_read_seq.sv
// Issues one read command from address zero and then clocks the full array.
module mw_read_seq
    import mw_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int WORDS  = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic start,
    output logic cs,
    output logic sk,
    output logic di
);

    localparam int CMD_LEN  = 3 + ADDR_W;
    localparam int DATA_LEN = DATA_W * WORDS;
    localparam int MAX_LEN  = (CMD_LEN > DATA_LEN) ? CMD_LEN : DATA_LEN;
    localparam int CNT_W    = $clog2(MAX_LEN + 1);

    typedef struct packed {
        sq_state_e        state;
        logic [CNT_W-1:0] cnt;
        logic             phase;
    } seq_t;

    seq_t d, q;

    always_comb begin
        d = q;
        if (!enable) begin
            d.state = SQ_IDLE;
            d.cnt   = '0;
            d.phase = 1'b0;
        end else begin
            case (q.state)
                SQ_IDLE: begin
                    if (start) begin
                        d.state = SQ_CMD;
                        d.cnt   = '0;
                        d.phase = 1'b0;
                    end
                end
                SQ_CMD: begin
                    d.phase = ~q.phase;
                    if (q.phase) begin
                        if (q.cnt == CNT_W'(CMD_LEN - 1)) begin
                            d.state = SQ_DATA;
                            d.cnt   = '0;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                SQ_DATA: begin
                    d.phase = ~q.phase;
                    if (q.phase) begin
                        if (q.cnt == CNT_W'(DATA_LEN - 1)) begin
                            d.state = SQ_IDLE;
                            d.cnt   = '0;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                default: d.state = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: SQ_IDLE, cnt: '0, phase: 1'b0};
        else        q <= d;
    end

    // Read opcode is start bit 1 then 10; address bits are all zero.
    assign cs = (q.state != SQ_IDLE);
    assign sk = cs & q.phase;
    assign di = (q.state == SQ_CMD) && (q.cnt < CNT_W'(2));

endmodule

// File: rtl/mw_eeprom_port.sv
module mw_eeprom_port #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int WORDS  = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       auto_mode,
    input  logic       auto_start,
    input  logic       reg_wr,
    input  logic [2:0] reg_wdata,
    output logic [3:0] reg_rdata,
    output logic       auto_absent,
    output logic       ee_cs,
    output logic       ee_di,
    input  logic       ee_do_i,
    input  logic       sk_pin_i,
    output logic       sk_pin_o,
    output logic       sk_pin_oe,
    input  logic       led_sk_fn,
    input  logic       led_do_fn,
    output logic       do_pin_o,
    output logic       do_pin_oe
);

    localparam int HOST_W = 3;

    typedef struct packed {
        logic [HOST_W-1:0] host;
        logic              mode;
        logic              guard;
        logic              sk_prev;
        logic              do_cap;
    } port_t;

    port_t d, q;

    logic present, det_done;
    logic seq_cs, seq_sk, seq_di;
    logic cs_out, sk_out, di_out;

    mw_presence u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (sk_pin_i),
        .present (present),
        .done    (det_done)
    );

    mw_read_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .WORDS  (WORDS)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (q.mode & ~q.guard),
        .start  (auto_start & present),
        .cs     (seq_cs),
        .sk     (seq_sk),
        .di     (seq_di)
    );

    // Pin ownership: guard cycle first, then sequencer or software bits.
    always_comb begin
        if (q.guard) begin
            cs_out = 1'b0;
            sk_out = 1'b0;
            di_out = 1'b0;
        end else if (q.mode) begin
            cs_out = seq_cs;
            sk_out = seq_sk;
            di_out = seq_di;
        end else begin
            cs_out = q.host[2];
            sk_out = q.host[1];
            di_out = q.host[0];
        end
    end

    always_comb begin
        d         = q;
        d.mode    = auto_mode;
        d.guard   = (auto_mode != q.mode);
        d.sk_prev = sk_out;
        if (reg_wr) d.host = reg_wdata;
        if (sk_out && !q.sk_prev) d.do_cap = ee_do_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ee_cs       = cs_out;
    assign ee_di       = di_out;
    assign sk_pin_oe   = det_done;
    assign sk_pin_o    = cs_out ? sk_out : led_sk_fn;
    assign do_pin_oe   = det_done & ~cs_out;
    assign do_pin_o    = led_do_fn;
    assign auto_absent = q.mode & ~present;
    assign reg_rdata   = {present, q.host[2], q.host[1], q.do_cap};

endmodule

// File: rtl/mw_eeprom_port_chk.sv
module mw_eeprom_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       auto_mode,
    input logic [3:0] reg_rdata,
    input logic       auto_absent,
    input logic       ee_cs,
    input logic       do_pin_oe
);

    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 1'b1;
    end

    // R8
    mode_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0 && auto_mode != $past(auto_mode)) |=> !ee_cs);

    // R7
    absent_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        auto_absent |-> !ee_cs);

    // R2
    presence_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> $stable(reg_rdata[3]));

    // R9
    do_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ee_cs |-> !do_pin_oe);

endmodule

bind mw_eeprom_port mw_eeprom_port_chk u_chk (.*);

// File: tb/sim_mw_eeprom_port.sv
`timescale 1ns/1ps
module sim_mw_eeprom_port;

    localparam int AW = 2;
    localparam int DW = 4;
    localparam int WD = 4;
    localparam int CMD_LEN  = 3 + AW;
    localparam int TOT_BITS = CMD_LEN + DW * WD;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       auto_mode = 1'b0;
    logic       auto_start = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_wdata = '0;
    logic [3:0] reg_rdata;
    logic       auto_absent, ee_cs, ee_di;
    logic       ee_do = 1'b0;
    logic       sk_pin_i, sk_pin_o, sk_pin_oe;
    logic       led_sk = 1'b0, led_do = 1'b0;
    logic       do_pin_o, do_pin_oe;
    logic       pull = 1'b1;

    int checks = 0;
    int errors = 0;
    bit ended = 0;

    always #2 clk = ~clk;

    assign sk_pin_i = sk_pin_oe ? sk_pin_o : pull;

    mw_eeprom_port #(.ADDR_W(AW), .DATA_W(DW), .WORDS(WD)) u0 (
        .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .auto_start(auto_start),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .auto_absent(auto_absent), .ee_cs(ee_cs), .ee_di(ee_di), .ee_do_i(ee_do),
        .sk_pin_i(sk_pin_i), .sk_pin_o(sk_pin_o), .sk_pin_oe(sk_pin_oe),
        .led_sk_fn(led_sk), .led_do_fn(led_do), .do_pin_o(do_pin_o),
        .do_pin_oe(do_pin_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] v);
        reg_wdata = v;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_run();
    end

    initial begin
        int rises, cs_cycles;
        logic prev_sk;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 cs", ee_cs, 0);
        chk("R1 sk_oe", sk_pin_oe, 0);
        chk("R1 do_oe", do_pin_oe, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: presence captured high
        chk("R2 present", reg_rdata[3], 1);
        chk("R2 sk_oe", sk_pin_oe, 1);
        pull = 1'b0;
        led_sk = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 hold", reg_rdata[3], 1);

        // R3 and R9: software register sweep
        for (int v = 0; v < 8; v++) begin
            led_sk = ~v[1];
            led_do = v[0];
            wr(3'(v));
            chk("R3 cs", ee_cs, v[2]);
            chk("R3 di", ee_di, v[0]);
            chk("R3 rd", reg_rdata[2:1], (v >> 1) & 3);
            chk("R9 sk_pad", sk_pin_o, v[2] ? v[1] : ~v[1] & 1);
            chk("R9 do_oe", do_pin_oe, v[2] ? 0 : 1);
            if (!v[2]) chk("R9 do_val", do_pin_o, v[0]);
        end

        // R4: data-out captured at clock rise only
        wr(3'b100);
        ee_do = 1'b1;
        wr(3'b110);
        @(negedge clk);
        chk("R4 cap1", reg_rdata[0], 1);
        ee_do = 1'b0;
        repeat (2) @(negedge clk);
        chk("R4 held", reg_rdata[0], 1);
        wr(3'b100);
        wr(3'b110);
        @(negedge clk);
        chk("R4 cap0", reg_rdata[0], 0);

        // R8: guard cycle on mode changes, software cs held high
        wr(3'b100);
        auto_mode = 1'b1;
        @(negedge clk);
        chk("R8 to_auto", ee_cs, 0);
        @(negedge clk);
        chk("R5 auto_idle", ee_cs, 0);
        auto_mode = 1'b0;
        @(negedge clk);
        chk("R8 to_host", ee_cs, 0);
        @(negedge clk);
        chk("R8 host_back", ee_cs, 1);

        // R5, R6: full automatic read
        auto_mode = 1'b1;
        repeat (2) @(negedge clk);
        chk("R5 host_ignored", ee_cs, 0);
        chk("R7 present_auto", auto_absent, 0);
        auto_start = 1'b1;
        rises = 0;
        cs_cycles = 0;
        prev_sk = 1'b0;
        for (int i = 0; i < 2 * TOT_BITS + 10; i++) begin
            @(negedge clk);
            if (i == 0) auto_start = 1'b0;
            if (ee_cs) begin
                cs_cycles++;
                if (sk_pin_o && !prev_sk) begin
                    chk("R6 di_bit", ee_di, (rises < 2) ? 1 : 0);
                    rises++;
                end
                chk("R9 do_released", do_pin_oe, 0);
            end
            prev_sk = ee_cs ? sk_pin_o : 1'b0;
        end
        chk("R6 cs_len", cs_cycles, 2 * TOT_BITS);
        chk("R6 rises", rises, TOT_BITS);

        // R7: no EEPROM detected
        auto_mode = 1'b0;
        rst_n = 1'b0;
        pull = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 absent", reg_rdata[3], 0);
        chk("R7 host_flag", auto_absent, 0);
        pull = 1'b1;
        auto_mode = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7 flag", auto_absent, 1);
        chk("R2 absent_hold", reg_rdata[3], 0);
        auto_start = 1'b1;
        cs_cycles = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            auto_start = 1'b0;
            if (ee_cs) cs_cycles++;
        end
        chk("R7 no_read", cs_cycles, 0);

        finish_run();
    end

endmodule